// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three active-low reset sources into an ordered reset sequence for a chip. The sources are a power-on input, a bidirectional hard-reset pin and a bidirectional soft-reset pin. The two pins are open-drain. Each pin is modelled as a read-back input and a pull-low enable. The block produces two reset outputs. The system-configuration reset (`sys_rst_n_o`) covers the memory controller, protection logic, interrupt controller and parallel I/O. The core reset (`core_rst_n_o`) covers only the internal logic. It also forwards a synchronised power-on reset.

A power-on event cascades into both the hard and the soft reset. The block samples the boot straps at the moment the power-on reset lets go: slave/master select, debug request, host-port enable and a boot-mode field. Requests that arrive on the pins pass through a two-flop synchronizer. Other logic, for example a watchdog, can raise a synchronous request. Each accepted request pulls the matching pins low for a fixed count, then releases them and waits a settle window before it listens again. While the block drives reset, it ignores its own read-back and any new requests. A sticky, write-1-to-clear cause register records what triggered the reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n_i` is low, `por_rst_n_o`, `sys_rst_n_o` and `core_rst_n_o` are low and both pin enables are high. This applies without waiting for a clock edge.
- R2: The strap inputs are captured at the last clock edge before the internal power-on reset releases, and the `cfg_*` outputs keep those values afterwards. Strap meanings: slave 0=master/1=slave, debug 0=normal/1=debug, host enable 0=off/1=on, boot 00=external memory/01=host port.
- R3: After `por_rst_n_o` rises, hard and soft reset stay active for exactly 16 more cycles, counting the cycle in which it rose.
- R4: A low on the hard pin seen through the synchronizer while the block is idle starts a hard reset. Both pin enables are high and both reset outputs are low for exactly 16 cycles.
- R5: The soft reset is active in every cycle in which the hard reset is active, and it releases together with the hard reset.
- R6: A low on the soft pin seen while the block is idle starts a soft-only reset. The soft pin enable is high and `core_rst_n_o` is low for exactly 8 cycles, and the hard side stays released.
- R7: A one-cycle `req_valid_i` while idle starts a hard reset (`req_hard_i`=1, 16 cycles) or a soft reset (`req_hard_i`=0, 8 cycles), sequenced like a pin request.
- R8: Pin lows and internal requests that arrive while a reset is driven or during the settle window start nothing and set no status bit.
- R9: After it releases the pins, the block stays released for 4 settle cycles plus one sampling cycle. A request that persists is therefore driven again exactly 5 cycles after the release.
- R10: `stat_o` bits: [0] power-on, [1] hard pin, [2] soft pin, [3] internal request. Bits are sticky. Writing 1 to a bit of `stat_clr_i` for one cycle clears that bit. Power-on reset forces the register to 0001.
- R11: When requests arrive in the same cycle, the priority is hard pin, then internal hard, then soft pin, then internal soft. Only the winner's status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n_i | input | 1 | External power-on reset, active low, asynchronous |
| hard_pin_i | input | 1 | Read-back of the open-drain hard-reset pin |
| soft_pin_i | input | 1 | Read-back of the open-drain soft-reset pin |
| hard_pin_oe_o | output | 1 | 1 pulls the hard-reset pin low |
| soft_pin_oe_o | output | 1 | 1 pulls the soft-reset pin low |
| req_valid_i | input | 1 | Synchronous internal reset request strobe |
| req_hard_i | input | 1 | Kind of internal request: 1 hard, 0 soft |
| strap_slave_i | input | 1 | Master/slave strap |
| strap_debug_i | input | 1 | Debug-mode strap |
| strap_host_en_i | input | 1 | Host-port enable strap |
| strap_boot_i | input | 2 | Boot-mode strap |
| cfg_slave_o | output | 1 | Latched master/slave select |
| cfg_debug_o | output | 1 | Latched debug request |
| cfg_host_en_o | output | 1 | Latched host-port enable |
| cfg_boot_o | output | 2 | Latched boot mode |
| por_rst_n_o | output | 1 | Synchronised power-on reset, active low |
| sys_rst_n_o | output | 1 | System-configuration domain reset, active low |
| core_rst_n_o | output | 1 | Core-logic domain reset, active low |
| stat_o | output | 4 | Sticky reset-cause register |
| stat_clr_i | input | 4 | Write-1-to-clear strobes for `stat_o` |

## Verification
The bench counts the exact length of each drive window for a hard request and a soft request. A counter that is off by one shows up as 15 or 17 cycles. It holds a soft request across the release to measure the five-cycle gap. A design that listens too early would see its own released drive and retrigger at once. It fires pin and internal requests into a running reset and into the settle window, and it fires a hard-pin and a soft internal request in the same cycle. A design that gates acceptance wrongly would extend the reset or set extra cause bits. Finally it scrambles the straps after power-on release and repeats power-on with a dirty status register, which catches late strap sampling and a cause register that power-on fails to reset.

// File: rtl/rst_pkg.sv
package rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HARD   = 2'd1,
        ST_SOFT   = 2'd2,
        ST_SETTLE = 2'd3
    } rst_state_e;

    localparam int unsigned STAT_W     = 4;
    localparam int unsigned STAT_POR   = 0;
    localparam int unsigned STAT_XHARD = 1;
    localparam int unsigned STAT_XSOFT = 2;
    localparam int unsigned STAT_INT   = 3;

    typedef struct packed {
        logic       slave;
        logic       debug;
        logic       host_en;
        logic [1:0] boot;
    } strap_t;

endpackage

// File: rtl/rst_por_sync.sv
// Power-on reset conditioner: asserts at once, releases after STAGES edges.
module rst_por_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n_i,
    output logic por_n_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) chain_q <= '0;
        else          chain_q <= chain_d;
    end

    assign por_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_pin_sync.sv
// Multi-flop synchronizer bank for asynchronous pin read-backs (idle high).
module rst_pin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        assign pin_o[g] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/rst_seq_fsm.sv
// Reset sequencer: accepts one request at a time, holds drive, then settles.
module rst_seq_fsm
    import rst_pkg::*;
#(
    parameter int unsigned HARD_CYC   = 16,
    parameter int unsigned SOFT_CYC   = 8,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xhard_req_i,
    input  logic              xsoft_req_i,
    input  logic              int_valid_i,
    input  logic              int_hard_i,
    output logic              hard_act_o,
    output logic              soft_act_o,
    output logic [STAT_W-1:0] cause_set_o
);
    localparam int unsigned MAX_AB = (HARD_CYC > SOFT_CYC) ? HARD_CYC : SOFT_CYC;
    localparam int unsigned MAX_C  = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
    localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        rst_state_e       state;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t              seq_d, seq_q;
    logic [STAT_W-1:0] cause_d;

    always_comb begin
        seq_d   = seq_q;
        cause_d = '0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (xhard_req_i) begin
                    seq_d.state         = ST_HARD;
                    seq_d.cnt           = CNT_W'(HARD_CYC - 1);
                    cause_d[STAT_XHARD] = 1'b1;
                end else if (int_valid_i && int_hard_i) begin
                    seq_d.state       = ST_HARD;
                    seq_d.cnt         = CNT_W'(HARD_CYC - 1);
                    cause_d[STAT_INT] = 1'b1;
                end else if (xsoft_req_i) begin
                    seq_d.state         = ST_SOFT;
                    seq_d.cnt           = CNT_W'(SOFT_CYC - 1);
                    cause_d[STAT_XSOFT] = 1'b1;
                end else if (int_valid_i) begin
                    seq_d.state       = ST_SOFT;
                    seq_d.cnt         = CNT_W'(SOFT_CYC - 1);
                    cause_d[STAT_INT] = 1'b1;
                end
            end
            ST_HARD, ST_SOFT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.cnt   = CNT_W'(SETTLE_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_SETTLE: begin
                if (seq_q.cnt == '0) seq_d.state = ST_IDLE;
                else                 seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    // Power-on leaves the sequencer in a full hard-reset hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_HARD;
            seq_q.cnt   <= CNT_W'(HARD_CYC - 1);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hard_act_o  = (seq_q.state == ST_HARD);
    assign soft_act_o  = (seq_q.state == ST_HARD) || (seq_q.state == ST_SOFT);
    assign cause_set_o = cause_d;
endmodule

// File: rtl/rst_cause_reg.sv
// Sticky cause register: set wins over clear, power-on forces its own bit.
module rst_cause_reg
    import rst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(1) << STAT_POR;

    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (stat_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= POR_VAL;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/rst_strap_latch.sv
// Tracks the straps while power-on is held; freezes them once it releases.
module rst_strap_latch
    import rst_pkg::*;
(
    input  logic   clk,
    input  logic   por_n_i,
    input  strap_t strap_i,
    output strap_t cfg_o
);
    strap_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = por_n_i ? cfg_q : strap_i;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_pkg::*;
#(
    parameter int unsigned HARD_CYC    = 16,
    parameter int unsigned SOFT_CYC    = 8,
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n_i,
    input  logic              hard_pin_i,
    input  logic              soft_pin_i,
    output logic              hard_pin_oe_o,
    output logic              soft_pin_oe_o,
    input  logic              req_valid_i,
    input  logic              req_hard_i,
    input  logic              strap_slave_i,
    input  logic              strap_debug_i,
    input  logic              strap_host_en_i,
    input  logic [1:0]        strap_boot_i,
    output logic              cfg_slave_o,
    output logic              cfg_debug_o,
    output logic              cfg_host_en_o,
    output logic [1:0]        cfg_boot_o,
    output logic              por_rst_n_o,
    output logic              sys_rst_n_o,
    output logic              core_rst_n_o,
    output logic [STAT_W-1:0] stat_o,
    input  logic [STAT_W-1:0] stat_clr_i
);
    logic              por_n_s;
    logic [1:0]        pin_s;
    logic              hard_act, soft_act;
    logic [STAT_W-1:0] cause_set;
    strap_t            strap_in, cfg;

    rst_por_sync #(.STAGES(SYNC_STAGES)) u_por (
        .clk     (clk),
        .por_n_i (por_n_i),
        .por_n_o (por_n_s)
    );

    rst_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_pins (
        .clk   (clk),
        .rst_n (por_n_s),
        .pin_i ({soft_pin_i, hard_pin_i}),
        .pin_o (pin_s)
    );

    rst_seq_fsm #(
        .HARD_CYC   (HARD_CYC),
        .SOFT_CYC   (SOFT_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (por_n_s),
        .xhard_req_i (!pin_s[0]),
        .xsoft_req_i (!pin_s[1]),
        .int_valid_i (req_valid_i),
        .int_hard_i  (req_hard_i),
        .hard_act_o  (hard_act),
        .soft_act_o  (soft_act),
        .cause_set_o (cause_set)
    );

    rst_cause_reg u_stat (
        .clk    (clk),
        .rst_n  (por_n_s),
        .set_i  (cause_set),
        .clr_i  (stat_clr_i),
        .stat_o (stat_o)
    );

    assign strap_in = '{slave: strap_slave_i, debug: strap_debug_i,
                        host_en: strap_host_en_i, boot: strap_boot_i};

    rst_strap_latch u_strap (
        .clk     (clk),
        .por_n_i (por_n_s),
        .strap_i (strap_in),
        .cfg_o   (cfg)
    );

    assign cfg_slave_o   = cfg.slave;
    assign cfg_debug_o   = cfg.debug;
    assign cfg_host_en_o = cfg.host_en;
    assign cfg_boot_o    = cfg.boot;

    assign hard_pin_oe_o = hard_act;
    assign soft_pin_oe_o = soft_act;
    assign por_rst_n_o   = por_n_s;
    assign sys_rst_n_o   = !hard_act;
    assign core_rst_n_o  = !soft_act;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int unsigned HARD_CYC   = 16,
    parameter int unsigned SOFT_CYC   = 8,
    parameter int unsigned SETTLE_CYC = 4
) (
    input logic       clk,
    input logic       por_n_i,
    input logic       por_n_s,
    input logic       hard_oe,
    input logic       soft_oe,
    input logic       sys_rst_n,
    input logic       core_rst_n,
    input logic [4:0] cfg,
    input logic [3:0] stat
);
    logic [15:0] hard_run, soft_run, idle_run;

    always_ff @(posedge clk or negedge por_n_s) begin
        if (!por_n_s) begin
            hard_run <= '0;
            soft_run <= '0;
            idle_run <= '0;
        end else begin
            hard_run <= hard_oe ? hard_run + 1'b1 : '0;
            soft_run <= soft_oe ? soft_run + 1'b1 : '0;
            if (soft_oe)             idle_run <= '0;
            else if (idle_run != '1) idle_run <= idle_run + 1'b1;
        end
    end

    // R1: power-on holds every reset output and both pin drives
    a_r1_por_cascade: assert property (@(negedge clk)
        !por_n_i |-> (!por_n_s && hard_oe && soft_oe && !sys_rst_n && !core_rst_n));

    // R2: strap copies frozen once power-on has released
    a_r2_straps_frozen: assert property (@(posedge clk) disable iff (!por_n_s)
        1'b1 |=> $stable(cfg));

    // R3 / R4: hard window length
    a_r4_hard_len: assert property (@(posedge clk) disable iff (!por_n_s)
        $fell(hard_oe) |-> (hard_run == 16'(HARD_CYC)));

    // R5: soft covers hard
    a_r5_soft_covers: assert property (@(posedge clk) disable iff (!por_n_s)
        hard_oe |-> soft_oe);

    a_r5_release_together: assert property (@(posedge clk) disable iff (!por_n_s)
        hard_oe |=> (hard_oe || !soft_oe));

    // R6: soft-only window length
    a_r6_soft_len: assert property (@(posedge clk) disable iff (!por_n_s)
        ($fell(soft_oe) && !$past(hard_oe)) |-> (soft_run == 16'(SOFT_CYC)));

    // R8: no cause recorded while a reset is being driven
    a_r8_no_cause_in_drive: assert property (@(posedge clk) disable iff (!por_n_s)
        (soft_oe && $past(soft_oe)) |-> !($rose(stat[1]) || $rose(stat[2]) || $rose(stat[3])));

    // R9: settle gap before any new drive
    a_r9_settle_gap: assert property (@(posedge clk) disable iff (!por_n_s)
        $rose(soft_oe) |-> (idle_run >= 16'(SETTLE_CYC + 1)));

    // R10: power-on forces the cause register
    a_r10_por_status: assert property (@(negedge clk)
        !por_n_s |-> (stat == 4'b0001));
endmodule

bind rst_sequencer rst_sequencer_chk #(
    .HARD_CYC   (HARD_CYC),
    .SOFT_CYC   (SOFT_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .por_n_i    (por_n_i),
    .por_n_s    (por_rst_n_o),
    .hard_oe    (hard_pin_oe_o),
    .soft_oe    (soft_pin_oe_o),
    .sys_rst_n  (sys_rst_n_o),
    .core_rst_n (core_rst_n_o),
    .cfg        ({cfg_slave_o, cfg_debug_o, cfg_host_en_o, cfg_boot_o}),
    .stat       (stat_o)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_hard = 1'b0, ext_soft = 1'b0;
    logic       req_valid = 1'b0, req_hard = 1'b0;
    logic [4:0] straps = 5'b0;
    logic [3:0] clr = 4'b0;

    logic       hard_oe, soft_oe, por_rst_n, sys_rst_n, core_rst_n;
    logic       c_slave, c_debug, c_host;
    logic [1:0] c_boot;
    logic [3:0] stat;
    logic       hard_pin, soft_pin;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // open-drain wiring: low if the block or the outside world pulls it
    assign hard_pin = !(hard_oe || ext_hard);
    assign soft_pin = !(soft_oe || ext_soft);

    always #10 clk = ~clk;

    rst_sequencer u_rst_sequencer (
        .clk             (clk),
        .por_n_i         (por_n),
        .hard_pin_i      (hard_pin),
        .soft_pin_i      (soft_pin),
        .hard_pin_oe_o   (hard_oe),
        .soft_pin_oe_o   (soft_oe),
        .req_valid_i     (req_valid),
        .req_hard_i      (req_hard),
        .strap_slave_i   (straps[4]),
        .strap_debug_i   (straps[3]),
        .strap_host_en_i (straps[2]),
        .strap_boot_i    (straps[1:0]),
        .cfg_slave_o     (c_slave),
        .cfg_debug_o     (c_debug),
        .cfg_host_en_o   (c_host),
        .cfg_boot_o      (c_boot),
        .por_rst_n_o     (por_rst_n),
        .sys_rst_n_o     (sys_rst_n),
        .core_rst_n_o    (core_rst_n),
        .stat_o          (stat),
        .stat_clr_i      (clr)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts cycles (sampled at negedge) with each drive / reset output active
    task automatic observe(input int n, inout int hc, inout int sc,
                           inout int sl, inout int cl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hc += int'(hard_oe);
            sc += int'(soft_oe);
            sl += int'(!sys_rst_n);
            cl += int'(!core_rst_n);
        end
    endtask

    task automatic clear_status();
        clr = 4'hF;
        @(negedge clk);
        clr = 4'h0;
        @(negedge clk);
    endtask

    task automatic t_por(input logic [4:0] s);
        int hc = 0, sc = 0, sl = 0, cl = 0;
        @(negedge clk);
        por_n  = 1'b0;
        straps = s;
        repeat (3) @(negedge clk);
        chk("R1 hard_oe", int'(hard_oe), 1);
        chk("R1 soft_oe", int'(soft_oe), 1);
        chk("R1 resets low", int'({por_rst_n, sys_rst_n, core_rst_n}), 0);
        chk("R10 por status", int'(stat), 1);
        por_n = 1'b1;
        do @(negedge clk); while (!por_rst_n);
        straps = ~s;
        hc = int'(hard_oe);
        sc = int'(soft_oe);
        observe(39, hc, sc, sl, cl);
        chk("R3 post-por hard cycles", hc, 16);
        chk("R3 post-por soft cycles", sc, 16);
        chk("R2 straps", int'({c_slave, c_debug, c_host, c_boot}), int'(s));
        chk("R10 status after por", int'(stat), 1);
    endtask

    task automatic t_ext_hard();
        int hc = 0, sc = 0, sl = 0, cl = 0;
        clear_status();
        chk("R10 cleared", int'(stat), 0);
        ext_hard = 1'b1;
        observe(3, hc, sc, sl, cl);
        ext_hard = 1'b0;
        observe(40, hc, sc, sl, cl);
        chk("R4 hard cycles", hc, 16);
        chk("R5 soft cycles in hard", sc, 16);
        chk("R4 sys reset cycles", sl, 16);
        chk("R4 core reset cycles", cl, 16);
        chk("R10 hard pin bit", int'(stat), 4'b0010);
    endtask

    task automatic t_ext_soft();
        int hc = 0, sc = 0, sl = 0, cl = 0;
        clear_status();
        ext_soft = 1'b1;
        observe(3, hc, sc, sl, cl);
        ext_soft = 1'b0;
        observe(30, hc, sc, sl, cl);
        chk("R6 hard cycles", hc, 0);
        chk("R6 soft cycles", sc, 8);
        chk("R6 sys reset cycles", sl, 0);
        chk("R6 core reset cycles", cl, 8);
        chk("R10 soft pin bit", int'(stat), 4'b0100);
    endtask

    task automatic t_internal(input logic kind);
        int hc = 0, sc = 0, sl = 0, cl = 0;
        clear_status();
        req_valid = 1'b1;
        req_hard  = kind;
        observe(1, hc, sc, sl, cl);
        req_valid = 1'b0;
        observe(35, hc, sc, sl, cl);
        chk("R7 hard cycles", hc, kind ? 16 : 0);
        chk("R7 soft cycles", sc, kind ? 16 : 8);
        chk("R10 internal bit", int'(stat), 4'b1000);
    endtask

    task automatic t_ignore();
        int hc = 0, sc = 0, sl = 0, cl = 0;
        clear_status();
        ext_hard = 1'b1;
        observe(3, hc, sc, sl, cl);
        ext_hard = 1'b0;
        observe(4, hc, sc, sl, cl);
        ext_soft  = 1'b1;
        req_valid = 1'b1;
        req_hard  = 1'b0;
        observe(1, hc, sc, sl, cl);
        req_valid = 1'b0;
        observe(2, hc, sc, sl, cl);
        ext_soft = 1'b0;
        observe(50, hc, sc, sl, cl);
        chk("R8 hard cycles", hc, 16);
        chk("R8 soft cycles", sc, 16);
        chk("R8 status", int'(stat), 4'b0010);
        // internal request during the settle window
        hc = 0; sc = 0;
        req_valid = 1'b1;
        req_hard  = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        do @(negedge clk); while (soft_oe);
        req_valid = 1'b1;
        observe(1, hc, sc, sl, cl);
        req_valid = 1'b0;
        observe(25, hc, sc, sl, cl);
        chk("R8 settle request ignored", sc, 0);
    endtask

    task automatic t_settle_gap();
        int on = 0, gap = 0;
        clear_status();
        ext_soft = 1'b1;
        do @(negedge clk); while (!soft_oe);
        while (soft_oe) begin on++; @(negedge clk); end
        while (!soft_oe && gap < 50) begin gap++; @(negedge clk); end
        ext_soft = 1'b0;
        chk("R9 first window", on, 8);
        chk("R9 release gap", gap, 5);
        repeat (30) @(negedge clk);
        chk("R9 quiet after", int'(soft_oe), 0);
    endtask

    task automatic t_priority();
        int hc = 0, sc = 0, sl = 0, cl = 0;
        clear_status();
        ext_hard = 1'b1;
        observe(2, hc, sc, sl, cl);
        req_valid = 1'b1;
        req_hard  = 1'b0;
        observe(1, hc, sc, sl, cl);
        req_valid = 1'b0;
        ext_hard  = 1'b0;
        observe(40, hc, sc, sl, cl);
        chk("R11 hard wins", hc, 16);
        chk("R11 only hard pin bit", int'(stat), 4'b0010);
    endtask

    task automatic t_clear_bits();
        // bit 1 still set from the previous test; set bit 2 too
        int hc = 0, sc = 0, sl = 0, cl = 0;
        ext_soft = 1'b1;
        observe(3, hc, sc, sl, cl);
        ext_soft = 1'b0;
        observe(30, hc, sc, sl, cl);
        chk("R10 sticky both", int'(stat), 4'b0110);
        clr = 4'b0010;
        @(negedge clk);
        clr = 4'b0000;
        @(negedge clk);
        chk("R10 selective clear", int'(stat), 4'b0100);
    endtask

    initial begin
        t_por(5'b1_0_1_01);
        t_ext_hard();
        t_ext_soft();
        t_internal(1'b1);
        t_internal(1'b0);
        t_ignore();
        t_settle_gap();
        t_priority();
        t_clear_bits();
        t_por(5'b0_1_0_00);
        finish_run();
    end
endmodule